// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single load or store and, alongside it, the value the base register should take after the access. It takes a 32-bit base, picks an offset from either a register operand or a zero-extended immediate, and adds the offset to the base or subtracts it. Three indexing modes decide which value goes to memory and which value goes back to the base register. Plain offset mode sends base±offset to memory and leaves the base untouched. Pre-indexed mode sends base±offset to memory and, when the instruction asks for it, writes that same value back. Post-indexed mode sends the unmodified base to memory and always advances the base by ±offset.

A size-dependent alignment check flags halfword and word addresses that do not sit on their natural boundary. A misaligned access never produces a base writeback. The datapath is combinational. A parameter selects an optional register stage at the output, which adds one cycle of latency.

Top module: `ls_addr_gen`

## Requirements
- R1: With `off_sel_i`=1 the offset is the full `reg_off_i`. With `off_sel_i`=0 it is `imm_off_i` zero-extended to the address width.
- R2: With `sub_i`=0 the computed value is base+offset. With `sub_i`=1 it is base−offset. Both are taken modulo 2^32, so results wrap.
- R3: With `mode_i`=2'b00 (plain offset), and also with the spare code 2'b11, `ea_o` is base±offset, `new_base_o` equals the base, and `wb_o` is 0.
- R4: With `mode_i`=2'b01 (pre-indexed), `ea_o` is base±offset, `new_base_o` equals `ea_o`, and `wb_o` = `wb_req_i` AND NOT misaligned.
- R5: With `mode_i`=2'b10 (post-indexed), `ea_o` equals the base and `new_base_o` is base±offset. `wb_o` is 1 whenever the access is aligned, whatever the value of `wb_req_i`.
- R6: The alignment check uses `size_i`. Code 2'b00 (byte) is never misaligned. Code 2'b01 (halfword) is misaligned when `ea_o[0]`=1. Codes 2'b10 and 2'b11 (word) are misaligned when `ea_o[1:0]`≠0.
- R7: A misaligned access forces `wb_o` to 0.
- R8: With the default `REG_OUT`=1, every output shows the result for the inputs sampled at the previous rising clock edge. `valid_o` follows `valid_i`. While `valid_o` is 0, `wb_o` and `misalign_o` are 0.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| base_i | input | 32 | Base register value |
| reg_off_i | input | 32 | Register offset operand |
| imm_off_i | input | 12 | Immediate offset magnitude |
| off_sel_i | input | 1 | 1 selects the register offset, 0 selects the immediate |
| sub_i | input | 1 | 1 subtracts the offset from the base |
| mode_i | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 treated as offset |
| wb_req_i | input | 1 | Writeback request (used in pre-indexed mode) |
| size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address |
| new_base_o | output | 32 | Updated base value |
| wb_o | output | 1 | Base writeback strobe |
| misalign_o | output | 1 | Alignment violation |

## Verification
The hardest case to reach is post-indexed mode with a misaligned base. Here the alignment check looks at the unmodified base and not at the sum. The base must be odd or off a word boundary, and the offset must be chosen so that base±offset is aligned, so that a check made on the wrong value would pass. The directed tests set exactly this case for both halfword and word sizes. They also cover the pre-indexed counterpart, where the base is aligned and the sum is not. Subtraction that crosses address zero exercises the wraparound.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {
    AM_OFFSET = 2'b00,
    AM_PRE    = 2'b01,
    AM_POST   = 2'b10,
    AM_SPARE  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } asize_e;
endpackage

// File: rtl/ls_offset_sel.sv
module ls_offset_sel #(
  parameter int AW    = 32,
  parameter int IMM_W = 12
) (
  input  logic             off_sel_i,
  input  logic [AW-1:0]    reg_off_i,
  input  logic [IMM_W-1:0] imm_off_i,
  output logic [AW-1:0]    off_o
);
  localparam int PAD = AW - IMM_W;

  logic [AW-1:0] imm_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign imm_ext = {{PAD{1'b0}}, imm_off_i};
    end else begin : g_nopad
      assign imm_ext = imm_off_i[AW-1:0];
    end
  endgenerate

  assign off_o = off_sel_i ? reg_off_i : imm_ext;
endmodule

// File: rtl/ls_addr_calc.sv
module ls_addr_calc
  import ls_agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  input  logic          sub_i,
  input  amode_e        mode_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] new_base_o
);
  logic [AW-1:0] sum;

  // two's-complement subtract, wraps at AW bits
  assign sum = sub_i ? (base_i + (~off_i) + AW'(1)) : (base_i + off_i);

  always_comb begin
    unique case (mode_i)
      AM_PRE: begin
        ea_o       = sum;
        new_base_o = sum;
      end
      AM_POST: begin
        ea_o       = base_i;
        new_base_o = sum;
      end
      default: begin
        ea_o       = sum;
        new_base_o = base_i;
      end
    endcase
  end
endmodule

// File: rtl/ls_align_chk.sv
module ls_align_chk
  import ls_agu_pkg::*;
(
  input  asize_e     size_i,
  input  logic [1:0] ea_lo_i,
  output logic       mis_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: mis_o = 1'b0;
      SZ_HALF: mis_o = ea_lo_i[0];
      default: mis_o = |ea_lo_i;
    endcase
  end
endmodule

// File: rtl/ls_out_stage.sv
module ls_out_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_pass
      assign q_o = rst_ni ? d_i : '0;
    end
  endgenerate
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMM_W   = 12,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    reg_off_i,
  input  logic [IMM_W-1:0] imm_off_i,
  input  logic             off_sel_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  input  logic             wb_req_i,
  input  logic [1:0]       size_i,
  output logic             valid_o,
  output logic [AW-1:0]    ea_o,
  output logic [AW-1:0]    new_base_o,
  output logic             wb_o,
  output logic             misalign_o
);
  localparam int PW = 2 * AW + 3;

  amode_e        mode;
  asize_e        size;
  logic [AW-1:0] off_c;
  logic [AW-1:0] ea_c;
  logic [AW-1:0] nb_c;
  logic          mis_raw;
  logic          mis_c;
  logic          wb_c;
  logic [PW-1:0] pipe_d;
  logic [PW-1:0] pipe_q;

  assign mode = amode_e'(mode_i);
  assign size = asize_e'(size_i);

  ls_offset_sel #(.AW(AW), .IMM_W(IMM_W)) u_off (
    .off_sel_i (off_sel_i),
    .reg_off_i (reg_off_i),
    .imm_off_i (imm_off_i),
    .off_o     (off_c)
  );

  ls_addr_calc #(.AW(AW)) u_calc (
    .base_i     (base_i),
    .off_i      (off_c),
    .sub_i      (sub_i),
    .mode_i     (mode),
    .ea_o       (ea_c),
    .new_base_o (nb_c)
  );

  ls_align_chk u_align (
    .size_i  (size),
    .ea_lo_i (ea_c[1:0]),
    .mis_o   (mis_raw)
  );

  assign mis_c = valid_i & mis_raw;

  // post always updates, pre only on request, never when misaligned
  assign wb_c = valid_i & ~mis_raw &
                ((mode == AM_POST) | ((mode == AM_PRE) & wb_req_i));

  assign pipe_d = {valid_i, wb_c, mis_c, ea_c, nb_c};

  ls_out_stage #(.W(PW), .REG(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pipe_d),
    .q_o    (pipe_q)
  );

  assign {valid_o, wb_o, misalign_o, ea_o, new_base_o} = pipe_q;

  // R5
  post_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode == AM_POST) |-> (ea_c == base_i));

  // R4
  pre_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode == AM_PRE && wb_c) |-> (nb_c == ea_c));

  // R3
  offset_nowb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == AM_OFFSET || mode == AM_SPARE) |-> (!wb_c && nb_c == base_i));

  // R7
  mis_nowb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !wb_o);

  // R6
  byte_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size == SZ_BYTE) |-> !mis_c);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_o && !misalign_o));
endmodule

// File: tb/ls_addr_gen_tb.sv
module ls_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [31:0] reg_off_i = '0;
  logic [11:0] imm_off_i = '0;
  logic        off_sel_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        wb_req_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic        valid_o;
  logic [31:0] ea_o;
  logic [31:0] new_base_o;
  logic        wb_o;
  logic        misalign_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ls_addr_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (valid_i),
    .base_i     (base_i),
    .reg_off_i  (reg_off_i),
    .imm_off_i  (imm_off_i),
    .off_sel_i  (off_sel_i),
    .sub_i      (sub_i),
    .mode_i     (mode_i),
    .wb_req_i   (wb_req_i),
    .size_i     (size_i),
    .valid_o    (valid_o),
    .ea_o       (ea_o),
    .new_base_o (new_base_o),
    .wb_o       (wb_o),
    .misalign_o (misalign_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one request, check outputs one cycle later
  task automatic run(string tag, logic [31:0] base, logic [31:0] roff,
                     logic [11:0] imm, logic osel, logic sub, logic [1:0] mode,
                     logic wbreq, logic [1:0] size);
    logic [31:0] off, sum, e_ea, e_nb;
    logic e_mis, e_wb;
    off  = osel ? roff : {20'd0, imm};
    sum  = sub ? base - off : base + off;
    e_ea = (mode == 2'b10) ? base : sum;
    e_nb = (mode == 2'b01 || mode == 2'b10) ? sum : base;
    e_mis = (size == 2'b00) ? 1'b0 : (size == 2'b01) ? e_ea[0] : (e_ea[1:0] != 2'b00);
    e_wb = !e_mis && ((mode == 2'b10) || (mode == 2'b01 && wbreq));
    @(negedge clk);
    valid_i = 1'b1; base_i = base; reg_off_i = roff; imm_off_i = imm;
    off_sel_i = osel; sub_i = sub; mode_i = mode; wb_req_i = wbreq; size_i = size;
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " ea"}, ea_o, e_ea);
    chk({tag, " new_base"}, new_base_o, e_nb);
    chk({tag, " wb"}, {31'd0, wb_o}, {31'd0, e_wb});
    chk({tag, " mis"}, {31'd0, misalign_o}, {31'd0, e_mis});
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 rst valid", {31'd0, valid_o}, 32'd0);
    chk("R9 rst ea", ea_o, 32'd0);
    chk("R9 rst nb", new_base_o, 32'd0);
    chk("R9 rst wb", {31'd0, wb_o}, 32'd0);
    chk("R9 rst mis", {31'd0, misalign_o}, 32'd0);
  endtask

  task automatic t_src;
    run("R1 imm", 32'h1000, 32'hdead_0000, 12'hffc, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10);
    run("R1 reg", 32'h1000, 32'h0001_0008, 12'h004, 1'b1, 1'b0, 2'b00, 1'b0, 2'b10);
  endtask

  task automatic t_arith;
    run("R2 add wrap", 32'hffff_fffc, 32'h8, 12'h0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b10);
    run("R2 sub wrap", 32'h0000_0004, 32'h0, 12'h00c, 1'b0, 1'b1, 2'b01, 1'b1, 2'b10);
    run("R2 sub down", 32'h0000_0100, 32'h4, 12'h0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b10);
  endtask

  task automatic t_modes;
    run("R3 offset wbreq", 32'h2000, 32'h0, 12'h010, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10);
    run("R3 spare code", 32'h2000, 32'h0, 12'h020, 1'b0, 1'b0, 2'b11, 1'b1, 2'b10);
    run("R4 pre wb", 32'h3000, 32'h0, 12'h008, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10);
    run("R4 pre nowb", 32'h3000, 32'h0, 12'h008, 1'b0, 1'b0, 2'b01, 1'b0, 2'b10);
    run("R5 post noreq", 32'h4000, 32'h0, 12'h004, 1'b0, 1'b0, 2'b10, 1'b0, 2'b10);
  endtask

  task automatic t_align;
    run("R6 byte odd", 32'h5001, 32'h0, 12'h002, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00);
    run("R6 half odd", 32'h5000, 32'h0, 12'h003, 1'b0, 1'b0, 2'b00, 1'b0, 2'b01);
    run("R6 half even", 32'h5000, 32'h0, 12'h006, 1'b0, 1'b0, 2'b00, 1'b0, 2'b01);
    run("R6 word code3 off2", 32'h5000, 32'h0, 12'h002, 1'b0, 1'b0, 2'b00, 1'b0, 2'b11);
    run("R7 post mis base", 32'h5002, 32'h0, 12'h002, 1'b0, 1'b0, 2'b10, 1'b1, 2'b10);
    run("R7 post half mis", 32'h5001, 32'h0, 12'h001, 1'b0, 1'b0, 2'b10, 1'b0, 2'b01);
    run("R7 pre mis sum", 32'h5000, 32'h0, 12'h001, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    valid_i = 1'b0; base_i = 32'h7001; imm_off_i = 12'h1; mode_i = 2'b10; size_i = 2'b10;
    @(negedge clk);
    chk("R8 idle valid", {31'd0, valid_o}, 32'd0);
    chk("R8 idle wb", {31'd0, wb_o}, 32'd0);
    chk("R8 idle mis", {31'd0, misalign_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_src;
    t_arith;
    t_modes;
    t_align;
    t_idle;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule